// File: doc/BRIEF.md
# Programmable Completion Timeout Timer

This block watches non-posted requests that are waiting for a completion. Each request is identified by a tag, and up to 32 tags can be tracked at once. An issue strobe starts a timer for its tag, and a completion strobe for the same tag stops it. A tag that runs past the programmed limit without a completion is reported once on a timeout strobe that carries the tag. Time is measured in ticks of an external one-microsecond strobe, so the block's own clock rate does not matter.

The limit is chosen by a 4-bit range select. The values are grouped into four bins of two sub-ranges each, and a capability vector advertises which bins are built in. Any select value that is reserved, or that names a bin outside the capability vector, falls back to a default limit. A disable input silences every timeout report, while the timers keep running underneath it.

Top module: `cto_timer`

## Requirements
- R1: After reset `timeout_valid_o` is low, and `range_cap_o` equals the `SUPPORTED_BINS` parameter (default 4'b0011). Bit 0 stands for the shortest bin and bit 3 for the longest.
- R2: The range select codes map to limits in microsecond ticks as follows: 1 → 1000, 2 → 10000 (bin bit 0); 5 → 55000, 6 → 210000 (bin bit 1); 9 → 900000, 10 → 3500000 (bin bit 2); 13 → 13000000, 14 → 64000000 (bin bit 3). A code takes effect only while its bin bit is set.
- R3: Code 0, every other code, and any code whose bin is not supported all select the default limit of 50000 ticks.
- R4: A tag issued on clock edge k counts one on every later edge that samples `tick_us_i` high. With the limit L in effect, `timeout_valid_o` is high with that tag just after the first edge that follows the one where the count reaches L. With the tick held high, that is edge k+L+1.
- R5: Edges that sample `tick_us_i` low leave every count unchanged.
- R6: A completion for an outstanding tag stops its timer, and no timeout is ever reported for that tag.
- R7: A completion that arrives in the same cycle in which its tag has reached the limit cancels that report. Other tags that have expired are still reported.
- R8: While `timeout_dis_i` is high, no timeout is reported, but counting continues. Once the input drops, any tag already at or past the limit is reported on the next edge.
- R9: Tags that expire together are reported one per cycle, in ascending tag order.
- R10: A tag that has been reported is no longer outstanding and is not reported again.
- R11: The limit is compared against the range select currently applied, not the one applied at issue time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | A request with `issue_tag_i` has been issued |
| issue_tag_i | input | 5 | Tag of the issued request |
| cpl_valid_i | input | 1 | A completion with `cpl_tag_i` has arrived |
| cpl_tag_i | input | 5 | Tag of the completed request |
| range_sel_i | input | 4 | Timeout range select code |
| timeout_dis_i | input | 1 | Suppresses all timeout reports |
| tick_us_i | input | 1 | One-microsecond time base strobe |
| timeout_valid_o | output | 1 | Timeout strobe |
| timeout_tag_o | output | 5 | Tag that timed out |
| range_cap_o | output | 4 | Supported bins, one bit per bin |

## Verification
The assertions assume that a tag is never issued while it is still outstanding. They also assume that a tag is never issued and completed in the same cycle, and that no tag is reissued in the cycle in which it expires. Under those conditions the checker's own record of outstanding tags, built only from the ports, covers every tag the block reports. The stimulus reuses a tag only after its completion or its report has been seen, and it issues and completes tags on separate cycles. Its long waits use the shorter limits, with the longest checked limit at 55000 ticks.

// File: rtl/cto_pkg.sv
package cto_pkg;
  localparam int unsigned LIM_A1  = 1000;
  localparam int unsigned LIM_A2  = 10000;
  localparam int unsigned LIM_B1  = 55000;
  localparam int unsigned LIM_B2  = 210000;
  localparam int unsigned LIM_C1  = 900000;
  localparam int unsigned LIM_C2  = 3500000;
  localparam int unsigned LIM_D1  = 13000000;
  localparam int unsigned LIM_D2  = 64000000;
  localparam int unsigned LIM_DEF = 50000;
  localparam int unsigned CNT_W   = $clog2(LIM_D2 + 1);
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned BINS    = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t range_limit(logic [SEL_W-1:0] sel, logic [BINS-1:0] cap);
    cnt_t lim;
    lim = CNT_W'(LIM_DEF);
    case (sel)
      4'd1:  if (cap[0]) lim = CNT_W'(LIM_A1);
      4'd2:  if (cap[0]) lim = CNT_W'(LIM_A2);
      4'd5:  if (cap[1]) lim = CNT_W'(LIM_B1);
      4'd6:  if (cap[1]) lim = CNT_W'(LIM_B2);
      4'd9:  if (cap[2]) lim = CNT_W'(LIM_C1);
      4'd10: if (cap[2]) lim = CNT_W'(LIM_C2);
      4'd13: if (cap[3]) lim = CNT_W'(LIM_D1);
      4'd14: if (cap[3]) lim = CNT_W'(LIM_D2);
      default: lim = CNT_W'(LIM_DEF);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/cto_range_decode.sv
module cto_range_decode
  import cto_pkg::*;
#(
  parameter logic [BINS-1:0] SUPPORTED_BINS = 4'b0011
) (
  input  logic [SEL_W-1:0] range_sel_i,
  output cnt_t             limit_o,
  output logic [BINS-1:0]  cap_o
);
  assign cap_o   = SUPPORTED_BINS;
  assign limit_o = range_limit(range_sel_i, SUPPORTED_BINS);
endmodule

// File: rtl/cto_tag_timers.sv
module cto_tag_timers
  import cto_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 32,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_valid_i,
  input  logic [TAG_W-1:0]    issue_tag_i,
  input  logic                cpl_valid_i,
  input  logic [TAG_W-1:0]    cpl_tag_i,
  input  logic                tick_i,
  input  logic                enable_i,
  input  cnt_t                limit_i,
  input  logic [NUM_TAGS-1:0] clear_i,
  output logic [NUM_TAGS-1:0] expired_o
);
  localparam cnt_t CNT_MAX = '1;

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_tag
    logic valid_q;
    cnt_t cnt_q;
    logic issue_hit, cpl_hit;

    assign issue_hit = issue_valid_i && (issue_tag_i == TAG_W'(i));
    assign cpl_hit   = cpl_valid_i && (cpl_tag_i == TAG_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
      end else if (issue_hit) begin
        valid_q <= 1'b1;
        cnt_q   <= '0;
      end else if (cpl_hit || clear_i[i]) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
      end else if (valid_q && tick_i && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    // completion in the expiry cycle masks the report
    assign expired_o[i] = valid_q && enable_i && !cpl_hit && !issue_hit
                          && (cnt_q >= limit_i);
  end
endmodule

// File: rtl/cto_expiry_arbiter.sv
module cto_expiry_arbiter #(
  parameter int unsigned NUM_TAGS = 32,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAGS-1:0] expired_i,
  output logic [NUM_TAGS-1:0] pick_o,
  output logic                valid_o,
  output logic [TAG_W-1:0]    tag_o
);
  logic             any;
  logic [TAG_W-1:0] idx;

  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (expired_i[i]) idx = TAG_W'(i);
    end
    any    = |expired_i;
    pick_o = any ? (NUM_TAGS'(1) << idx) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else begin
      valid_o <= any;
      tag_o   <= any ? idx : '0;
    end
  end
endmodule

// File: rtl/cto_timer.sv
module cto_timer
  import cto_pkg::*;
#(
  parameter int unsigned      NUM_TAGS       = 32,
  parameter logic [BINS-1:0]  SUPPORTED_BINS = 4'b0011,
  localparam int unsigned     TAG_W          = $clog2(NUM_TAGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             cpl_valid_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  input  logic [SEL_W-1:0] range_sel_i,
  input  logic             timeout_dis_i,
  input  logic             tick_us_i,
  output logic             timeout_valid_o,
  output logic [TAG_W-1:0] timeout_tag_o,
  output logic [BINS-1:0]  range_cap_o
);
  cnt_t                limit;
  logic [NUM_TAGS-1:0] expired;
  logic [NUM_TAGS-1:0] pick;

  cto_range_decode #(.SUPPORTED_BINS(SUPPORTED_BINS)) u_decode (
    .range_sel_i (range_sel_i),
    .limit_o     (limit),
    .cap_o       (range_cap_o)
  );

  cto_tag_timers #(.NUM_TAGS(NUM_TAGS)) u_timers (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_valid_i (issue_valid_i),
    .issue_tag_i   (issue_tag_i),
    .cpl_valid_i   (cpl_valid_i),
    .cpl_tag_i     (cpl_tag_i),
    .tick_i        (tick_us_i),
    .enable_i      (!timeout_dis_i),
    .limit_i       (limit),
    .clear_i       (pick),
    .expired_o     (expired)
  );

  cto_expiry_arbiter #(.NUM_TAGS(NUM_TAGS)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expired_i (expired),
    .pick_o    (pick),
    .valid_o   (timeout_valid_o),
    .tag_o     (timeout_tag_o)
  );
endmodule

// File: rtl/cto_timer_chk.sv
module cto_timer_chk #(
  parameter int unsigned NUM_TAGS = 32,
  localparam int unsigned TAG_W   = $clog2(NUM_TAGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic [TAG_W-1:0] issue_tag_i,
  input logic             cpl_valid_i,
  input logic [TAG_W-1:0] cpl_tag_i,
  input logic             timeout_dis_i,
  input logic             timeout_valid_o,
  input logic [TAG_W-1:0] timeout_tag_o
);
  logic [NUM_TAGS-1:0] out_q;

  // outstanding set seen from the ports alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (issue_valid_i && issue_tag_i == TAG_W'(i)) out_q[i] <= 1'b1;
        else if ((cpl_valid_i && cpl_tag_i == TAG_W'(i)) ||
                 (timeout_valid_o && timeout_tag_o == TAG_W'(i))) out_q[i] <= 1'b0;
      end
    end
  end

  p_silent_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_dis_i |=> !timeout_valid_o);

  p_cpl_cancels_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i |=> !(timeout_valid_o && timeout_tag_o == $past(cpl_tag_i)));

  p_tag_outstanding_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_valid_o |-> out_q[timeout_tag_o]);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q == '0) |=> !timeout_valid_o);
endmodule

bind cto_timer cto_timer_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .issue_valid_i   (issue_valid_i),
  .issue_tag_i     (issue_tag_i),
  .cpl_valid_i     (cpl_valid_i),
  .cpl_tag_i       (cpl_tag_i),
  .timeout_dis_i   (timeout_dis_i),
  .timeout_valid_o (timeout_valid_o),
  .timeout_tag_o   (timeout_tag_o)
);

// File: tb/sim_cto_timer.sv
`timescale 1ns/1ps
module sim_cto_timer;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0;
  logic [TAG_W-1:0] issue_tag = '0;
  logic             cpl_valid = 1'b0;
  logic [TAG_W-1:0] cpl_tag = '0;
  logic [3:0]       range_sel = 4'd1;
  logic             dis = 1'b0;
  logic             tick = 1'b1;
  logic             to_valid;
  logic [TAG_W-1:0] to_tag;
  logic [3:0]       cap;

  cto_timer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_tag_i(issue_tag),
    .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag),
    .range_sel_i(range_sel), .timeout_dis_i(dis), .tick_us_i(tick),
    .timeout_valid_o(to_valid), .timeout_tag_o(to_tag), .range_cap_o(cap)
  );

  always #2.5 clk = ~clk;

  typedef struct { int tag; int cyc; string req; } exp_t;
  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    unexp = 0;
  string cur_req = "R1";
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        checks++; fails++;
        $display("FAIL %s: missing timeout tag %0d, actual none, expected at cycle %0d",
                 q[0].req, q[0].tag, q[0].cyc);
        void'(q.pop_front());
      end
      if (to_valid) begin
        if (q.size() == 0 || q[0].cyc != cyc) begin
          unexp++;
          checks++; fails++;
          $display("FAIL %s: unexpected timeout tag %0d at cycle %0d, expected none",
                   cur_req, to_tag, cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (int'(to_tag) != e.tag) begin
            fails++;
            $display("FAIL %s: timeout tag actual %0d expected %0d at cycle %0d",
                     e.req, to_tag, e.tag, cyc);
          end
        end
      end
    end
  end

  task automatic expect_to(int tag, int at, string req);
    exp_t e;
    e.tag = tag; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic issue(int tag, output int d);
    d = cyc;
    issue_valid = 1'b1; issue_tag = TAG_W'(tag);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic complete(int tag);
    cpl_valid = 1'b1; cpl_tag = TAG_W'(tag);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drained(string req);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected timeouts still pending, expected 0", req, q.size());
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual still running, expected finished");
    summary();
  end

  initial begin
    int d, t0, u0s;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (to_valid !== 1'b0) begin fails++; $display("FAIL R1: timeout_valid actual %b expected 0", to_valid); end
    checks++;
    if (cap !== 4'b0011) begin fails++; $display("FAIL R1: cap actual %b expected 0011", cap); end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 code 1 -> 1000 ticks
    cur_req = "R4"; range_sel = 4'd1; tick = 1'b1;
    issue(4, d);
    expect_to(4, d + 1000 + 2, "R2");
    wait_until(d + 1010); drained("R4");

    // R5 tick pause of 200 edges
    cur_req = "R5";
    issue(12, d);
    expect_to(12, d + 1000 + 202, "R5");
    wait_until(d + 300); tick = 1'b0;
    wait_until(d + 500); tick = 1'b1;
    wait_until(d + 1210); drained("R5");

    // R6 completion stops the timer
    cur_req = "R6";
    issue(9, d);
    wait_until(d + 500); complete(9);
    u0s = unexp;
    wait_until(d + 1600);
    checks++;
    if (unexp != u0s) begin fails++; $display("FAIL R6: strobes actual %0d expected 0", unexp - u0s); end

    // R8 disable silences, tracking continues
    cur_req = "R8"; dis = 1'b1;
    issue(5, d);
    u0s = unexp;
    wait_until(d + 1500);
    checks++;
    if (unexp != u0s) begin fails++; $display("FAIL R8: strobes while disabled actual %0d expected 0", unexp - u0s); end
    dis = 1'b0;
    expect_to(5, cyc + 1, "R8");
    @(negedge clk); @(negedge clk); drained("R8");

    // R9 simultaneous expiry, ascending order
    cur_req = "R9"; tick = 1'b0;
    issue(20, d); issue(7, d); issue(3, d);
    t0 = cyc; tick = 1'b1;
    expect_to(3, t0 + 1001, "R9");
    expect_to(7, t0 + 1002, "R9");
    expect_to(20, t0 + 1003, "R9");
    wait_until(t0 + 1020); drained("R9");

    // R10 no second report for the tags above
    cur_req = "R10";
    u0s = unexp;
    wait_until(t0 + 2200);
    checks++;
    if (unexp != u0s) begin fails++; $display("FAIL R10: repeat strobes actual %0d expected 0", unexp - u0s); end

    // R7 completion in expiry cycle cancels
    cur_req = "R7"; tick = 1'b0;
    issue(1, d); issue(2, d);
    t0 = cyc; tick = 1'b1;
    expect_to(2, t0 + 1001, "R7");
    wait_until(t0 + 1000); complete(1);
    wait_until(t0 + 1100); drained("R7");

    // R2 code 2 -> 10000 ticks
    cur_req = "R2"; range_sel = 4'd2;
    issue(30, d);
    expect_to(30, d + 10000 + 2, "R2");
    wait_until(d + 10010); drained("R2");

    // R2 code 5 -> 55000 ticks
    range_sel = 4'd5;
    issue(31, d);
    expect_to(31, d + 55000 + 2, "R2");
    wait_until(d + 55010); drained("R2");

    // R3 R11 unsupported code 13, switched live to reserved 3 then 0
    cur_req = "R3"; range_sel = 4'd13;
    issue(0, d);
    expect_to(0, d + 50000 + 2, "R3");
    wait_until(d + 20000); range_sel = 4'd3;
    wait_until(d + 35000); range_sel = 4'd0;
    wait_until(d + 50010); drained("R3");

    // R11 live shrink: limit lowered below current count
    cur_req = "R11"; range_sel = 4'd2;
    issue(8, d);
    wait_until(d + 3000);
    range_sel = 4'd1;
    expect_to(8, cyc + 1, "R11");
    @(negedge clk); @(negedge clk); drained("R11");

    summary();
  end
endmodule